// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the serial bit clock and the frame clock of an audio port that runs as clock master. It is clocked by the master clock itself and counts that clock down into bit periods and frames. The frame length follows from a master-clock ratio code and a sample-rate range code. The number of bit clocks in each frame is the slot count times the bit clocks per slot. The bit period is the frame length divided by that number of bit clocks. A transmitter alongside uses the bit-start strobe, the frame-start strobe and the slot index to place its data.

A configuration whose frame cannot be split into a whole number of bit periods is rejected. The same holds for a bit clock that would run faster than the allowed maximum, and for a reserved code. A rejected configuration raises an error flag and every clock output stays low. New settings are only taken up at a frame boundary, so a frame that has already started always completes with the settings it began with.

Top module: `mclk_frame_gen`

## Requirements
- R1: With ratio code 0,1,2,3,4 meaning a multiplier r of 1,2,3,4,6 and range code fs from 0 to 4, one frame lasts (512 × r) / 2^fs master-clock cycles, measured from one `frame_stb` to the next.
- R2: A frame holds slots × width bit periods, each marked by one `bit_stb` pulse. `slots_code` 0,1,2,3 selects 2, 4, 8 or 16 slots. `slot_w16` = 1 selects 16 bit clocks per slot and 0 selects 32. `slot_idx` counts 0 up to slots − 1 and advances once every width bits.
- R3: Each bit period lasts D = frame length / (slots × width) cycles. `bclk` rises in the cycle of `bit_stb` and stays high for ceil(D/2) cycles, so an odd D, as in the divide-by-3 case, gets the closest duty cycle it can.
- R4: With `pulse_mode` = 0, `fclk` is high for the first half of the bits of a frame. With `pulse_mode` = 1 it is high only during the first bit period.
- R5: `frame_stb` occurs only together with `bit_stb` and slot 0. The first frame starts in the cycle after the first clock edge that follows reset release.
- R6: A ratio code or range code above 4 raises `cfg_err` and holds `bclk`, `fclk`, `bit_stb` and `frame_stb` low. Once a valid configuration is applied, `cfg_err` clears and a frame starts after the next clock edge.
- R7: A configuration is rejected with `cfg_err` when the frame is not a whole multiple of slots × width, or when D falls below the minimum divide. The minimum divide is 2, or more if the master clock divided by the maximum bit-clock rate of 24.576 MHz requires it.
- R8: A configuration change made during a frame takes effect only at the next frame boundary. The running frame keeps its original length.
- R9: While `rst_n` is low, all clock, strobe and error outputs are low and `slot_idx` is 0. Reset may be applied at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Master-clock ratio code (0..4 valid) |
| range_code | input | 3 | Sample-rate range code (0..4 valid) |
| slot_w16 | input | 1 | 1: 16 bit clocks per slot, 0: 32 |
| slots_code | input | 2 | Slot count 2, 4, 8, 16 |
| pulse_mode | input | 1 | Frame clock as one-bit pulse |
| bclk | output | 1 | Bit clock level |
| bit_stb | output | 1 | One-cycle strobe at each bit start |
| fclk | output | 1 | Frame clock level |
| frame_stb | output | 1 | One-cycle strobe at each frame start |
| slot_idx | output | 4 | Current slot number |
| cfg_err | output | 1 | Active configuration is unsupported |

## Verification
The hard case is a configuration reload that falls in the same cycle as the last bit of a running frame. In that cycle the frame-boundary wrap and the loading of new settings both happen. The bench changes the settings ten cycles into a 512-cycle frame and checks that the next frame start still comes exactly 512 cycles after the previous one. It then checks that the frame after it has the new length. Error entry at a boundary and the restart after an error are judged the same way, by counting cycles to the next `frame_stb` and confirming that the outputs stay silent in between.

// File: rtl/mclk_frame_gen.sv
module mclk_frame_gen #(
  parameter int MCLK_KHZ     = 36864,
  parameter int BCLK_MAX_KHZ = 24576,
  parameter int DIV_W        = 8,
  parameter int IDX_W        = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_code,
  input  logic [2:0] range_code,
  input  logic       slot_w16,
  input  logic [1:0] slots_code,
  input  logic       pulse_mode,
  output logic       bclk,
  output logic       bit_stb,
  output logic       fclk,
  output logic       frame_stb,
  output logic [3:0] slot_idx,
  output logic       cfg_err
);
  localparam int CEIL_DIV = (MCLK_KHZ + BCLK_MAX_KHZ - 1) / BCLK_MAX_KHZ;
  localparam int MIN_DIV  = (CEIL_DIV < 2) ? 2 : CEIL_DIV;
  localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

  logic [2:0] a_ratio, a_range;
  logic       a_w16, a_pulse, live;
  logic [1:0] a_slots;
  logic [DIV_W-1:0] bcnt;
  logic [IDX_W-1:0] biti;

  logic       odd3;
  logic [1:0] k;
  always_comb begin
    odd3 = 1'b0;
    k    = 2'd0;
    case (a_ratio)
      3'd1: k = 2'd1;
      3'd2: odd3 = 1'b1;
      3'd3: k = 2'd2;
      3'd4: begin odd3 = 1'b1; k = 2'd1; end
      default: ;
    endcase
  end

  logic [2:0] wl;
  logic [4:0] ex, lim, sh;
  logic       bad, ovr, err, run;
  logic [DIV_W-1:0] div, hi_len;
  logic [3:0] flog;
  logic [IDX_W:0] bpf, last_idx, half;

  assign wl   = a_w16 ? 3'd4 : 3'd5;
  assign ex   = {2'b0, a_range} + {3'b0, a_slots} + 5'd1 + {2'b0, wl};
  assign lim  = 5'd9 + {3'b0, k};
  assign ovr  = ex > lim;
  assign sh   = lim - ex;
  assign bad  = (a_ratio > 3'd4) | (a_range > 3'd4);
  assign div  = (odd3 ? DIV_W'(3) : DIV_W'(1)) << sh[2:0];
  assign err  = bad | ovr | (div < MIN_DIV_V);
  assign hi_len = (div + DIV_W'(1)) >> 1;

  assign flog     = {2'b0, a_slots} + 4'd1 + {1'b0, wl};
  assign bpf      = (IDX_W+1)'(1) << flog;
  assign last_idx = bpf - (IDX_W+1)'(1);
  assign half     = bpf >> 1;

  logic last_bit, load;
  assign last_bit = bcnt == (div - DIV_W'(1));
  assign load     = ~live | err | (last_bit & ({1'b0, biti} == last_idx));
  assign run      = live & ~err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live    <= 1'b0;
      a_ratio <= 3'd0;
      a_range <= 3'd0;
      a_w16   <= 1'b0;
      a_slots <= 2'd0;
      a_pulse <= 1'b0;
      bcnt    <= '0;
      biti    <= '0;
    end else begin
      live <= 1'b1;
      if (load) begin
        a_ratio <= ratio_code;
        a_range <= range_code;
        a_w16   <= slot_w16;
        a_slots <= slots_code;
        a_pulse <= pulse_mode;
        bcnt    <= '0;
        biti    <= '0;
      end else if (last_bit) begin
        bcnt <= '0;
        biti <= biti + IDX_W'(1);
      end else begin
        bcnt <= bcnt + DIV_W'(1);
      end
    end
  end

  assign bclk      = run & (bcnt < hi_len);
  assign bit_stb   = run & (bcnt == '0);
  assign frame_stb = bit_stb & (biti == '0);
  assign fclk      = run & (a_pulse ? (biti == '0) : ({1'b0, biti} < half));
  assign slot_idx  = 4'(biti >> wl);
  assign cfg_err   = live & err;
endmodule

// File: rtl/mclk_frame_gen_chk.sv
module mclk_frame_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bclk,
  input logic       bit_stb,
  input logic       fclk,
  input logic       frame_stb,
  input logic [3:0] slot_idx,
  input logic       cfg_err
);
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(bclk | fclk | bit_stb | frame_stb)); // R6
  AST_FRAME_ON_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (bit_stb && slot_idx == 4'd0)); // R5
  AST_BCLK_RISE_AT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> bit_stb); // R3
  AST_BIT_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> bclk); // R3
  AST_FCLK_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> fclk); // R4
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_err && !bit_stb) |-> $stable(slot_idx)); // R2
endmodule

bind mclk_frame_gen mclk_frame_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .bit_stb(bit_stb), .fclk(fclk),
  .frame_stb(frame_stb), .slot_idx(slot_idx), .cfg_err(cfg_err)
);

// File: tb/tb_mclk_frame_gen.sv
`timescale 1ns/1ps
module tb_mclk_frame_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ratio_code = 3'd0, range_code = 3'd0;
  logic slot_w16 = 1'b0, pulse_mode = 1'b0;
  logic [1:0] slots_code = 2'd0;
  logic bclk, bit_stb, fclk, frame_stb, cfg_err;
  logic [3:0] slot_idx;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mclk_frame_gen dut (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .range_code(range_code),
    .slot_w16(slot_w16), .slots_code(slots_code), .pulse_mode(pulse_mode),
    .bclk(bclk), .bit_stb(bit_stb), .fclk(fclk), .frame_stb(frame_stb),
    .slot_idx(slot_idx), .cfg_err(cfg_err)
  );

  // {ratio, range, w16, slots, pulse, err, period}
  localparam bit [22:0] VEC [0:11] = '{
    {3'd0, 3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 12'd128},
    {3'd2, 3'd2, 1'b0, 2'd0, 1'b1, 1'b0, 12'd384},
    {3'd5, 3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0},
    {3'd2, 3'd4, 1'b1, 2'd0, 1'b0, 1'b0, 12'd96},
    {3'd4, 3'd1, 1'b1, 2'd2, 1'b1, 1'b0, 12'd1536},
    {3'd0, 3'd5, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0},
    {3'd3, 3'd0, 1'b0, 2'd3, 1'b0, 1'b0, 12'd2048},
    {3'd0, 3'd3, 1'b0, 2'd0, 1'b0, 1'b1, 12'd0},
    {3'd1, 3'd3, 1'b1, 2'd1, 1'b0, 1'b0, 12'd128},
    {3'd0, 3'd4, 1'b0, 2'd3, 1'b0, 1'b1, 12'd0},
    {3'd0, 3'd0, 1'b0, 2'd0, 1'b1, 1'b0, 12'd512},
    {3'd4, 3'd4, 1'b1, 2'd3, 1'b0, 1'b1, 12'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input bit [22:0] v);
    ratio_code = v[22:20]; range_code = v[19:17]; slot_w16 = v[16];
    slots_code = v[15:14]; pulse_mode = v[13];
  endtask

  task automatic wait_fs();
    int n = 0;
    while (!frame_stb && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int cyc, output int bits, output int fhi_first,
                         output int fhi, output int smax, output int errs);
    cyc = 0; bits = 0; fhi_first = 0; fhi = 0; smax = 0; errs = 0;
    do begin
      if (bit_stb) bits++;
      if (bclk && bits == 1) fhi_first++;
      if (fclk) fhi++;
      if (int'(slot_idx) > smax) smax = int'(slot_idx);
      if (cfg_err) errs++;
      cyc++;
      @(negedge clk);
    end while (!frame_stb && cyc < 6000);
  endtask

  task automatic run_valid(input bit [22:0] v);
    int cyc, bits, hi, fhi, smax, errs, nsl, wid, per, d;
    apply(v);
    @(negedge clk);
    wait_fs();
    measure(cyc, bits, hi, fhi, smax, errs);
    per = int'(v[11:0]);
    nsl = 2 << v[15:14];
    wid = v[16] ? 16 : 32;
    d = per / (nsl * wid);
    chk("R1 frame period", cyc, per);
    chk("R2 bits per frame", bits, nsl * wid);
    chk("R2 last slot index", smax, nsl - 1);
    chk("R3 bclk high cycles", hi, (d + 1) / 2);
    chk("R4 fclk high cycles", fhi, v[13] ? d : per / 2);
    chk("R6 no error on valid config", errs, 0);
  endtask

  task automatic run_err(input bit [22:0] v);
    int n = 0, act = 0;
    string tag;
    tag = (v[22:20] > 3'd4 || v[19:17] > 3'd4) ? "R6" : "R7";
    apply(v);
    while (!cfg_err && n < 6000) begin @(negedge clk); n++; end
    chk({tag, " cfg_err raised"}, int'(cfg_err), 1);
    repeat (20) begin
      if (bclk | fclk | bit_stb | frame_stb) act++;
      @(negedge clk);
    end
    chk({tag, " outputs silent in error"}, act, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c;
    apply(VEC[0]);
    repeat (4) @(negedge clk);
    chk("R9 outputs in reset", int'({bclk, fclk, bit_stb, frame_stb, cfg_err, slot_idx}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 first frame after reset", int'({frame_stb, bit_stb, bclk}), 7);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][12]) run_err(VEC[i]);
      else run_valid(VEC[i]);
    end

    // recovery from error state: frame begins after one edge
    apply(VEC[10]);
    @(negedge clk);
    chk("R6 recovery frame start", int'({frame_stb, cfg_err}), 2);

    // change mid-frame: old 512-cycle frame must complete
    repeat (10) @(negedge clk);
    apply(VEC[0]);
    c = 10;
    while (!frame_stb && c < 6000) begin @(negedge clk); c++; end
    chk("R8 running frame keeps length", c, 512);
    begin
      int cyc, bits, hi, fhi, smax, errs;
      measure(cyc, bits, hi, fhi, smax, errs);
      chk("R8 new length after boundary", cyc, 128);
    end

    // reset mid-operation
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 outputs in mid-run reset", int'({bclk, fclk, bit_stb, frame_stb, cfg_err, slot_idx}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 restart after reset", int'(frame_stb), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule